// File: doc/BRIEF.md
# Received-Frame Store Sequencer

This block sequences how one received CAN or CAN FD frame is written into a 32-bit receive FIFO memory, one word per cycle. It takes single-cycle commands from the protocol engine and turns each of them into memory-write controls. The commands are a metadata-ready pulse, a data-word-ready pulse, a frame-valid pulse and an abort pulse. For each write the block drives a one-hot selector that picks the word source, and a write-request strobe for writes through the main write pointer. It also controls an alternate pointer that is used to back-fill timestamp words.

A frame starts with four header writes: the frame-format word, the identifier word, and two timestamp slots, low half first. The block then writes one word for each data-ready pulse until the frame-valid pulse arrives. When the timestamp is taken at the start of the frame, the frame is complete at frame-valid. When it is taken at the end of the frame, the block first writes both timestamp halves again through the alternate pointer, into the slots reserved earlier, and only then raises its completion pulse. Surrounding logic owns the memory, the pointers, overrun detection and the commit.

Top module: `rx_frame_store_seq`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, every output is low and `sel_o` is zero.
- R2: In the four cycles after an accepted metadata pulse, `sel_o` is 0x01, 0x02, 0x04 and 0x10 in that order (frame format, identifier, timestamp low, timestamp high), with `wr_req_o` high in each of them.
- R3: `ovr_clr_o` pulses in the same cycle as a metadata pulse that is accepted in idle.
- R4: After the header, each cycle with `data_rdy_i` high drives `sel_o` = 0x40 with `wr_req_o` high in that same cycle. A waiting cycle without `data_rdy_i` drives `sel_o` = 0 and `wr_req_o` low.
- R5: `alt_ptr_save_o` is high in exactly the cycle of the header timestamp-low write (`sel_o` = 0x04).
- R6: In end-of-frame timestamp mode (`ts_at_end_i` = 1 at frame start), the cycle after frame-valid drives `sel_o` = 0x08 and the next cycle drives `sel_o` = 0x20. Both cycles have `alt_ptr_sel_o` and `alt_ptr_inc_o` high and `wr_req_o` low, and `frame_done_o` is high only in the second cycle.
- R7: In start-of-frame timestamp mode (`ts_at_end_i` = 0), `frame_done_o` is high in the frame-valid cycle and no back-fill write follows. A data word given in that same cycle is still written.
- R8: An abort pulse forces all outputs low in its cycle and returns the block to idle at any point of a frame.
- R9: An erase pulse acts like abort. In idle it also keeps a coincident metadata pulse from starting a frame.
- R10: `data_rdy_i` and `frame_ok_i` are ignored in idle and during the header. `meta_rdy_i` is ignored while a frame is in progress.
- R11: The timestamp mode is latched when the frame starts. Changing `ts_at_end_i` later in the frame has no effect on that frame.
- R12: `sel_o` is one-hot or zero, and `wr_req_o` is never high together with `alt_ptr_sel_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| erase_i | input | 1 | Buffer erase command, forces idle |
| ts_at_end_i | input | 1 | 1: timestamp at end of frame, 0: at start of frame |
| meta_rdy_i | input | 1 | Metadata-ready pulse, starts a frame |
| data_rdy_i | input | 1 | Data word ready pulse |
| frame_ok_i | input | 1 | Frame-valid pulse |
| abort_i | input | 1 | Frame abort pulse |
| sel_o | output | 7 | One-hot word source selector |
| wr_req_o | output | 1 | Write request through the main pointer |
| alt_ptr_sel_o | output | 1 | Route the write through the alternate pointer |
| alt_ptr_save_o | output | 1 | Alternate pointer captures the current write position |
| alt_ptr_inc_o | output | 1 | Alternate pointer advances |
| frame_done_o | output | 1 | Frame complete, commit may proceed |
| ovr_clr_o | output | 1 | Clear the per-frame overrun flag |

## Verification
On every cycle the assertions check the structure of the controls. The selector stays one-hot or zero, and main-pointer writes never coincide with alternate-pointer writes. A save is followed by the timestamp-high header write, and an overrun clear is followed by the frame-format write. The two back-fill writes come as an adjacent pair that ends in completion, and abort or erase leaves no write in the following cycle. Only the bench scenarios can show the rest. These are the full header order, the timing of completion in each timestamp mode, commands being ignored in the wrong phase, mode latching across a mid-frame change, and a data word that coincides with frame-valid.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int SEL_W       = 7;
    localparam int SEL_FMT     = 0;
    localparam int SEL_ID      = 1;
    localparam int SEL_TSL_HDR = 2;
    localparam int SEL_TSL_BF  = 3;
    localparam int SEL_TSH_HDR = 4;
    localparam int SEL_TSH_BF  = 5;
    localparam int SEL_DATA    = 6;
    localparam int ST_W        = 3;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE,
        ST_FMT,
        ST_ID,
        ST_TSL,
        ST_TSH,
        ST_WAIT,
        ST_BFL,
        ST_BFH
    } seq_st_e;

    typedef struct packed {
        seq_st_e st;
        logic    end_ts;
    } seq_reg_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             wr;
        logic             alt_sel;
        logic             alt_save;
        logic             alt_inc;
        logic             done;
        logic             ovr_clr;
    } ctl_t;

endpackage

// File: rtl/rxs_seq_ctrl.sv
module rxs_seq_ctrl
    import rxs_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    kill_i,
    input  logic    meta_rdy_i,
    input  logic    frame_ok_i,
    input  logic    ts_at_end_i,
    output seq_st_e st_o,
    output logic    end_ts_o
);

    seq_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (meta_rdy_i) begin
                    r_d.st     = ST_FMT;
                    r_d.end_ts = ts_at_end_i;
                end
            end
            ST_FMT:  r_d.st = ST_ID;
            ST_ID:   r_d.st = ST_TSL;
            ST_TSL:  r_d.st = ST_TSH;
            ST_TSH:  r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (frame_ok_i) begin
                    r_d.st = r_q.end_ts ? ST_BFL : ST_IDLE;
                end
            end
            ST_BFL:  r_d.st = ST_BFH;
            ST_BFH:  r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
        if (kill_i) begin
            r_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_IDLE, end_ts: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign st_o     = r_q.st;
    assign end_ts_o = r_q.end_ts;

endmodule

// File: rtl/rxs_out_dec.sv
module rxs_out_dec
    import rxs_pkg::*;
(
    input  seq_st_e st_i,
    input  logic    end_ts_i,
    input  logic    kill_i,
    input  logic    meta_rdy_i,
    input  logic    data_rdy_i,
    input  logic    frame_ok_i,
    output ctl_t    ctl_o
);

    logic [SEL_W-1:0] hit;
    logic             back_fill;
    logic             main_wr;
    logic             done_raw;

    // Raw per-source request, before abort/erase gating.
    always_comb begin
        hit                 = '0;
        hit[SEL_FMT]        = (st_i == ST_FMT);
        hit[SEL_ID]         = (st_i == ST_ID);
        hit[SEL_TSL_HDR]    = (st_i == ST_TSL);
        hit[SEL_TSH_HDR]    = (st_i == ST_TSH);
        hit[SEL_DATA]       = (st_i == ST_WAIT) && data_rdy_i;
        hit[SEL_TSL_BF]     = (st_i == ST_BFL);
        hit[SEL_TSH_BF]     = (st_i == ST_BFH);
    end

    for (genvar gi = 0; gi < SEL_W; gi++) begin : g_sel
        assign ctl_o.sel[gi] = hit[gi] & ~kill_i;
    end

    assign back_fill = (st_i == ST_BFL) || (st_i == ST_BFH);
    assign main_wr   = hit[SEL_FMT] | hit[SEL_ID] | hit[SEL_TSL_HDR]
                     | hit[SEL_TSH_HDR] | hit[SEL_DATA];
    assign done_raw  = (st_i == ST_BFH)
                     || ((st_i == ST_WAIT) && frame_ok_i && !end_ts_i);

    assign ctl_o.wr       = main_wr & ~kill_i;
    assign ctl_o.alt_sel  = back_fill & ~kill_i;
    assign ctl_o.alt_inc  = back_fill & ~kill_i;
    assign ctl_o.alt_save = hit[SEL_TSL_HDR] & ~kill_i;
    assign ctl_o.done     = done_raw & ~kill_i;
    assign ctl_o.ovr_clr  = (st_i == ST_IDLE) && meta_rdy_i && !kill_i;

endmodule

// File: rtl/rx_frame_store_seq.sv
module rx_frame_store_seq
    import rxs_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             erase_i,
    input  logic             ts_at_end_i,
    input  logic             meta_rdy_i,
    input  logic             data_rdy_i,
    input  logic             frame_ok_i,
    input  logic             abort_i,
    output logic [SEL_W-1:0] sel_o,
    output logic             wr_req_o,
    output logic             alt_ptr_sel_o,
    output logic             alt_ptr_save_o,
    output logic             alt_ptr_inc_o,
    output logic             frame_done_o,
    output logic             ovr_clr_o
);

    logic    kill;
    seq_st_e st;
    logic    end_ts;
    ctl_t    ctl;

    assign kill = abort_i | erase_i;

    rxs_seq_ctrl u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .kill_i      (kill),
        .meta_rdy_i  (meta_rdy_i),
        .frame_ok_i  (frame_ok_i),
        .ts_at_end_i (ts_at_end_i),
        .st_o        (st),
        .end_ts_o    (end_ts)
    );

    rxs_out_dec u_dec (
        .st_i       (st),
        .end_ts_i   (end_ts),
        .kill_i     (kill),
        .meta_rdy_i (meta_rdy_i),
        .data_rdy_i (data_rdy_i),
        .frame_ok_i (frame_ok_i),
        .ctl_o      (ctl)
    );

    assign sel_o          = ctl.sel;
    assign wr_req_o       = ctl.wr;
    assign alt_ptr_sel_o  = ctl.alt_sel;
    assign alt_ptr_save_o = ctl.alt_save;
    assign alt_ptr_inc_o  = ctl.alt_inc;
    assign frame_done_o   = ctl.done;
    assign ovr_clr_o      = ctl.ovr_clr;

endmodule

// File: rtl/rx_frame_store_seq_chk.sv
module rx_frame_store_seq_chk
    import rxs_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             erase_i,
    input logic             ts_at_end_i,
    input logic             meta_rdy_i,
    input logic             data_rdy_i,
    input logic             frame_ok_i,
    input logic             abort_i,
    input logic [SEL_W-1:0] sel_o,
    input logic             wr_req_o,
    input logic             alt_ptr_sel_o,
    input logic             alt_ptr_save_o,
    input logic             alt_ptr_inc_o,
    input logic             frame_done_o,
    input logic             ovr_clr_o
);

    logic kill;
    assign kill = abort_i | erase_i;

    a_r12_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(sel_o));

    a_r12_wr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_req_o && alt_ptr_sel_o));

    a_r3_clr_then_fmt: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovr_clr_o |=> kill || (sel_o[SEL_FMT] && wr_req_o));

    a_r5_save_then_tsh: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alt_ptr_save_o |=> kill || (sel_o[SEL_TSH_HDR] && wr_req_o));

    a_r4_data_needs_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_o[SEL_DATA] |-> (data_rdy_i && wr_req_o));

    a_r6_bf_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alt_ptr_inc_o && sel_o[SEL_TSL_BF])
            |=> kill || (sel_o[SEL_TSH_BF] && alt_ptr_inc_o && frame_done_o));

    a_r6_done_after_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_done_o && alt_ptr_sel_o) |-> $past(alt_ptr_inc_o));

    a_r8_abort_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_i |=> (!wr_req_o && !alt_ptr_sel_o));

    a_r9_erase_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        erase_i |=> (!wr_req_o && !alt_ptr_sel_o));

endmodule

bind rx_frame_store_seq rx_frame_store_seq_chk chk_i (.*);

// File: tb/rx_frame_store_seq_tb_top.sv
module rx_frame_store_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       erase = 1'b0, ts_end = 1'b0, meta = 1'b0;
    logic       data = 1'b0, ok = 1'b0, abort = 1'b0;
    logic [6:0] sel;
    logic       wr, asel, asave, ainc, done, oclr;

    always #5 clk = ~clk;

    rx_frame_store_seq dut_i (
        .clk_i(clk), .rst_ni(rst_n), .erase_i(erase), .ts_at_end_i(ts_end),
        .meta_rdy_i(meta), .data_rdy_i(data), .frame_ok_i(ok), .abort_i(abort),
        .sel_o(sel), .wr_req_o(wr), .alt_ptr_sel_o(asel),
        .alt_ptr_save_o(asave), .alt_ptr_inc_o(ainc),
        .frame_done_o(done), .ovr_clr_o(oclr)
    );

    typedef struct {
        logic [12:0] v;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   fin = 1'b0;

    // Monitor: one expected item per cycle, compared mid-cycle.
    always @(negedge clk) begin
        exp_t        e;
        logic [12:0] act;
        if (q.size() > 0) begin
            e   = q.pop_front();
            act = {sel, wr, asel, asave, ainc, done, oclr};
            n_vec++;
            if (act !== e.v) begin
                n_bad++;
                $display("FAIL %s: sel/wr/asel/asave/ainc/done/oclr act=%b exp=%b",
                         e.tag, act, e.v);
            end
        end
    end

    // Driver: inputs one cycle, expected outputs for that cycle.
    task automatic cyc(input logic m, d, o, a, er,
                       input logic [6:0] s, input logic w, as, sv, ic, dn, oc,
                       input string tag);
        exp_t x;
        @(posedge clk);
        #1;
        meta = m; data = d; ok = o; abort = a; erase = er;
        x.v   = {s, w, as, sv, ic, dn, oc};
        x.tag = tag;
        q.push_back(x);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 7'h00, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic hdr();
        cyc(1, 0, 0, 0, 0, 7'h00, 0, 0, 0, 0, 0, 1, "R3");
        cyc(0, 0, 0, 0, 0, 7'h01, 1, 0, 0, 0, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, 7'h02, 1, 0, 0, 0, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, 7'h04, 1, 0, 1, 0, 0, 0, "R5");
        cyc(0, 0, 0, 0, 0, 7'h10, 1, 0, 0, 0, 0, 0, "R2");
    endtask

    task automatic word();
        cyc(0, 1, 0, 0, 0, 7'h40, 1, 0, 0, 0, 0, 0, "R4");
    endtask

    task automatic fin_end(input string tag);
        cyc(0, 0, 1, 0, 0, 7'h00, 0, 0, 0, 0, 0, 0, tag);
        cyc(0, 0, 0, 0, 0, 7'h08, 0, 1, 0, 1, 0, 0, tag);
        cyc(0, 0, 0, 0, 0, 7'h20, 0, 1, 0, 1, 1, 0, tag);
    endtask

    task automatic fin_start(input string tag);
        cyc(0, 0, 1, 0, 0, 7'h00, 0, 0, 0, 0, 1, 0, tag);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!fin) begin
            n_bad++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) idle("R1");
        rst_n = 1'b1;
        idle("R1");

        // End-of-frame timestamp, three data words with gaps (R2, R4, R6)
        ts_end = 1'b1;
        hdr();
        idle("R4");
        word();
        word();
        idle("R4");
        word();
        fin_end("R6");
        idle("R6");

        // Start-of-frame timestamp, no back-fill after commit (R7)
        ts_end = 1'b0;
        hdr();
        word();
        word();
        fin_start("R7");
        idle("R7");

        // End mode with no data words
        ts_end = 1'b1;
        hdr();
        fin_end("R6");

        // Data word coinciding with frame-valid in start mode (R7)
        ts_end = 1'b0;
        hdr();
        cyc(0, 1, 1, 0, 0, 7'h40, 1, 0, 0, 0, 1, 0, "R7");
        idle("R7");

        // R8: abort in data phase, then idle ignores commands
        ts_end = 1'b1;
        hdr();
        word();
        cyc(0, 1, 0, 1, 0, 7'h00, 0, 0, 0, 0, 0, 0, "R8");
        cyc(0, 1, 0, 0, 0, 7'h00, 0, 0, 0, 0, 0, 0, "R8");
        cyc(0, 0, 1, 0, 0, 7'h00, 0, 0, 0, 0, 0, 0, "R8");
        // R8: abort inside the header
        cyc(1, 0, 0, 0, 0, 7'h00, 0, 0, 0, 0, 0, 1, "R3");
        cyc(0, 0, 0, 0, 0, 7'h01, 1, 0, 0, 0, 0, 0, "R2");
        cyc(0, 0, 0, 1, 0, 7'h00, 0, 0, 0, 0, 0, 0, "R8");
        idle("R8");

        // R9: erase in data phase and erase blocking a start in idle
        hdr();
        word();
        cyc(0, 1, 0, 0, 1, 7'h00, 0, 0, 0, 0, 0, 0, "R9");
        idle("R9");
        cyc(1, 0, 0, 0, 1, 7'h00, 0, 0, 0, 0, 0, 0, "R9");
        idle("R9");

        // R10: commands in the wrong phase are ignored
        ts_end = 1'b0;
        cyc(1, 1, 1, 0, 0, 7'h00, 0, 0, 0, 0, 0, 1, "R10");
        cyc(0, 1, 1, 0, 0, 7'h01, 1, 0, 0, 0, 0, 0, "R10");
        cyc(0, 1, 0, 0, 0, 7'h02, 1, 0, 0, 0, 0, 0, "R10");
        cyc(0, 0, 1, 0, 0, 7'h04, 1, 0, 1, 0, 0, 0, "R10");
        cyc(0, 1, 1, 0, 0, 7'h10, 1, 0, 0, 0, 0, 0, "R10");
        cyc(1, 0, 0, 0, 0, 7'h00, 0, 0, 0, 0, 0, 0, "R10");
        word();
        fin_start("R10");
        idle("R10");

        // R11: mode latched at frame start
        ts_end = 1'b1;
        hdr();
        ts_end = 1'b0;
        word();
        fin_end("R11");
        hdr();
        ts_end = 1'b1;
        fin_start("R11");
        idle("R11");

        @(negedge clk);
        #1;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R1: pending items act=%0d exp=0", q.size());
        end
        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule